// File: doc/BRIEF.md
# Dual-Rate Serial Baud Generator

This block turns a bus clock into two independent bit-rate strobes for a UART-style serial port: one for the transmitter and one for the receiver. Software programs a single 8-bit rate register that picks a shared first-stage prescale factor and a separate power-of-two divisor for each direction. Two extra 8-bit fine-tuning registers, one per direction, can take the place of that side's power-of-two divisor with any value from 1 to 255. This allows rates that the power-of-two steps cannot reach.

Each direction has its own prescale counter and its own divide counter. Each strobe is a one-clock pulse that repeats every N bus clocks, where N is the prescale factor times the divisor in effect for that side. A write that changes a side's configuration restarts that side's counters, so the first strobe after a write comes exactly N clocks later. The side that was not touched keeps its phase.

Top module: `dual_baud_gen`

## Requirements
- R1: After reset, the rate register and both fine-tuning registers read as zero. Both ticks therefore assert on every clock.
- R2: Rate register bits 7:6 select the prescale factor. Code 00 gives 1, code 01 gives 3, code 10 gives 4 and code 11 gives 13.
- R3: Rate register bits 5:3 select the transmit divisor as 2 raised to the code, giving 1 to 128.
- R4: Rate register bits 2:0 select the receive divisor as 2 raised to the code, giving 1 to 128.
- R5: For each side, the tick is high for exactly one clock in every N clocks, where N is the prescale factor times that side's divisor. After a restart, the first tick comes in the N-th clock.
- R6: A nonzero transmit fine-tuning register (wr_sel = 1) replaces the transmit power-of-two divisor. Writing zero to it brings the power-of-two divisor back.
- R7: A nonzero receive fine-tuning register (wr_sel = 2) replaces the receive power-of-two divisor. Writing zero to it brings the power-of-two divisor back.
- R8: A write to the rate register (wr_sel = 0) restarts both sides. A write to a fine-tuning register restarts only its own side, and the other side keeps its tick phase.
- R9: When a side's total division is 1, its tick stays high on every clock.
- R10: A write with wr_sel = 3 changes no register and restarts no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 2 | Target: 0 rate, 1 transmit fine, 2 receive fine, 3 none |
| wr_data | input | 8 | Write data |
| tx_tick | output | 1 | Transmit bit-rate pulse |
| rx_tick | output | 1 | Receive bit-rate pulse |

## Verification
The hardest case to reach from the ports is the one where one side is reconfigured while the other side is in mid-period. In that case the untouched side must not slip its phase by even one clock. To reach it, the stimulus first sets unequal periods on the two sides through the rate register. It then writes one fine-tuning register at an arbitrary point in the other side's cycle. The scoreboard keeps a separate phase counter for each side and resets only the counter of the side whose restart is announced, so one lost or extra clock on the untouched side shows up as a mismatch.

// File: rtl/dual_baud_gen.sv
module dual_baud_gen #(
  parameter int REG_W  = 8,
  parameter int PF0    = 1,
  parameter int PF1    = 3,
  parameter int PF2    = 4,
  parameter int PF3    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             tx_tick,
  output logic             rx_tick
);

  localparam int PF_MAX = (PF3 > PF2 ? (PF3 > PF1 ? (PF3 > PF0 ? PF3 : PF0) : PF1) : PF2);
  localparam int PC_W   = $clog2(PF_MAX + 1);
  localparam int CODE_W = 3;
  localparam logic [1:0] SEL_RATE = 2'd0;
  localparam logic [1:0] SEL_NONE = 2'd3;

  logic [REG_W-1:0]            rate_q;
  logic [1:0][REG_W-1:0]       fine_q;
  logic [PC_W-1:0]             pfac;
  logic [1:0]                  tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      fine_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    rate_q    <= wr_data;
        2'd1:    fine_q[0] <= wr_data;
        2'd2:    fine_q[1] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rate_q[REG_W-1 -: 2])
      2'd0:    pfac = PC_W'(PF0);
      2'd1:    pfac = PC_W'(PF1);
      2'd2:    pfac = PC_W'(PF2);
      default: pfac = PC_W'(PF3);
    endcase
  end

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam logic [1:0] SEL_OWN = 2'(s + 1);
    logic [CODE_W-1:0] code;
    logic [REG_W-1:0]  dfac;
    logic [PC_W-1:0]   pcnt_q;
    logic [REG_W-1:0]  dcnt_q;
    logic              restart, pwrap, dwrap, unit;

    assign code    = (s == 0) ? rate_q[5:3] : rate_q[2:0];
    assign dfac    = (|fine_q[s]) ? fine_q[s] : (REG_W'(1) << code);
    assign restart = wr_en && (wr_sel == SEL_RATE || wr_sel == SEL_OWN);
    assign pwrap   = (pcnt_q == pfac - PC_W'(1));
    assign dwrap   = (dcnt_q == dfac - REG_W'(1));
    assign unit    = (pfac == PC_W'(1)) && (dfac == REG_W'(1));
    assign tick[s] = pwrap && dwrap;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pcnt_q <= '0;
        dcnt_q <= '0;
      end else if (restart) begin
        pcnt_q <= '0;
        dcnt_q <= '0;
      end else if (pwrap) begin
        pcnt_q <= '0;
        dcnt_q <= dwrap ? '0 : dcnt_q + REG_W'(1);
      end else begin
        pcnt_q <= pcnt_q + PC_W'(1);
      end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pcnt_q < pfac) && (dcnt_q < dfac));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (tick[s] == unit));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[s] && !unit && !wr_en) |=> !tick[s]);

    p_unit_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      unit |-> tick[s]);
  end

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_NONE) |=> ($stable(rate_q) && $stable(fine_q)));

  assign tx_tick = tick[0];
  assign rx_tick = tick[1];

endmodule

// File: tb/dual_baud_gen_test.sv
module dual_baud_gen_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    rs_tx;
    bit    rs_rx;
    int    n_tx;
    int    n_rx;
    string tag;
  } cfg_item_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic       tx_tick, rx_tick;

  int tests = 0, fails = 0;
  bit mon_on = 0;
  bit done = 0;
  cfg_item_t q[$];

  logic [7:0] sh_rate = 0;
  logic [7:0] sh_fine[2] = '{8'd0, 8'd0};

  dual_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int total_n(int side);
    int pf, dv;
    case (sh_rate[7:6])
      2'd0: pf = 1;
      2'd1: pf = 3;
      2'd2: pf = 4;
      default: pf = 13;
    endcase
    if (sh_fine[side] != 0) dv = sh_fine[side];
    else dv = 1 << ((side == 0) ? sh_rate[5:3] : sh_rate[2:0]);
    return pf * dv;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [7:0] d, input string tag);
    cfg_item_t it;
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 0;
    case (sel)
      2'd0: sh_rate = d;
      2'd1: sh_fine[0] = d;
      2'd2: sh_fine[1] = d;
      default: ;
    endcase
    it.rs_tx = (sel == 2'd0 || sel == 2'd1);
    it.rs_rx = (sel == 2'd0 || sel == 2'd2);
    it.n_tx  = total_n(0);
    it.n_rx  = total_n(1);
    it.tag   = tag;
    q.push_back(it);
  endtask

  task automatic run(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  // Scoreboard monitor: per-side phase counters
  initial begin
    int c_tx, c_rx, n_tx, n_rx;
    string t_tx, t_rx;
    bit e;
    cfg_item_t it;
    c_tx = 0; c_rx = 0; n_tx = 1; n_rx = 1; t_tx = "R1"; t_rx = "R1";
    forever begin
      @(negedge clk);
      if (mon_on) begin
        while (q.size() > 0) begin
          it = q.pop_front();
          if (it.rs_tx) begin c_tx = 0; n_tx = it.n_tx; t_tx = it.tag; end
          if (it.rs_rx) begin c_rx = 0; n_rx = it.n_rx; t_rx = it.tag; end
          if (!it.rs_tx && !it.rs_rx) begin t_tx = it.tag; t_rx = it.tag; end
        end
        c_tx++; c_rx++;
        e = (c_tx % n_tx) == 0;
        tests++;
        if (tx_tick !== e) begin
          fails++;
          $display("FAIL %s tx_tick: actual %b expected %b (N=%0d phase=%0d)", t_tx, tx_tick, e, n_tx, c_tx);
        end
        e = (c_rx % n_rx) == 0;
        tests++;
        if (rx_tick !== e) begin
          fails++;
          $display("FAIL %s rx_tick: actual %b expected %b (N=%0d phase=%0d)", t_rx, rx_tick, e, n_rx, c_rx);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    run(20);                                  // R1 reset state, R9 unit rate
    wr(2'd0, 8'b01_001_010, "R2 R3 R4 R5");   // 3*2=6, 3*4=12
    run(60);
    wr(2'd0, 8'b10_111_000, "R2 R3 R5 R9");   // 4*128=512, 4*1=4
    run(1100);
    wr(2'd0, 8'b11_000_111, "R2 R4 R5");      // 13, 13*128=1664
    run(3400);
    wr(2'd0, 8'b00_011_101, "R3 R4 R5");      // 8, 32
    run(100);
    wr(2'd0, 8'b01_010_001, "R8");            // 12, 6
    run(17);
    wr(2'd1, 8'd5, "R6 R8");                  // tx 15, rx keeps phase
    run(61);
    wr(2'd2, 8'd7, "R7 R8");                  // rx 21, tx keeps phase
    run(90);
    wr(2'd3, 8'hFF, "R10");                   // ignored, phases kept
    run(70);
    wr(2'd1, 8'd0, "R6");                     // tx back to 12
    run(50);
    wr(2'd2, 8'd0, "R7");                     // rx back to 6
    run(50);
    wr(2'd0, 8'h00, "R9");                    // both unit rate
    run(20);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule